// File: doc/BRIEF.md
# Five-Bank Lockstep Register File with Broadcast Writeback

This block holds five separate banks of architectural registers that one instruction stream can drive together. An issued instruction carries a 4-bit bank-group code that picks a preset set of banks. Every bank in that set reads the same register numbers from its own copy of the registers, and later writes its own result to the same destination number. This lets software unroll a loop across banks without vector instructions. Banks never read one another. The only way data crosses between banks is a broadcast ("splat") write.

A 2-bit splat code changes the meaning of an instruction. The operation then runs in bank 1 alone, whatever the group code says. Its bank-1 result is also written into bank 2, or into all five banks. A second write source, the load-splat channel, puts loaded data into banks 1 and 2 together, or into every bank. Address arithmetic can therefore stay in the first two banks. Each bank has one write port. When a load splat and an instruction writeback reach the same bank in the same cycle, the load splat takes that port and a conflict flag is raised.

The read side and the writeback side each decode their own group and splat codes. The read data is combinational. All writes commit on the rising clock edge.

Top module: `mbank_rf`

## Requirements
- R1: With splat code 0, the group code sets the active banks, where bit i of `rd_en_o` stands for bank i+1. The codes are: 0 gives bank 1, 1 gives bank 2, 2 gives banks 1 and 2, 3 gives banks 2 to 5, 4 gives all banks, and 5 gives banks 3 to 5.
- R2: Group codes 6 to 15 (with splat code 0) and splat code 3 are illegal. While the instruction is valid they raise `illegal_o`, give no read enables, and cause no register writes from that instruction.
- R3: A legal writeback with splat code 0 writes lane i of `wb_res` to register `wb_rd` of each active bank i. Banks outside the group keep their contents.
- R4: Splat code 1 makes bank 1 the only active bank, whatever the group code. Lane 0 (the bank-1 result) is written to banks 1 and 2.
- R5: Splat code 2 makes bank 1 the only active bank. Lane 0 is written to all five banks.
- R6: Each active bank returns its own registers `iss_rs_a` and `iss_rs_b` on its two read lanes. The lanes of inactive banks read as zero.
- R7: Register 0 of every bank reads as zero. A write to register 0 changes nothing and leaves that bank's `wr_en_o` bit low.
- R8: A load splat writes `ld_data` to register `ld_rd` of banks 1 and 2 when `ld_all` is 0, and of all banks when `ld_all` is 1.
- R9: When a load splat and a legal instruction writeback target the same bank in one cycle, that bank takes the load data and `conflict_o` is high. Banks reached only by the instruction are still written normally. `conflict_o` stays low when the two sources share no bank.
- R10: Writes take effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R11: Reset clears every register in every bank to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all banks |
| iss_valid | input | 1 | Issue-side instruction valid |
| iss_group | input | 4 | Issue-side bank-group code |
| iss_splat | input | 2 | Issue-side splat code |
| iss_rs_a | input | 5 | First source register number |
| iss_rs_b | input | 5 | Second source register number |
| rd_en_o | output | 5 | Per-bank read enables |
| rd_a_o | output | 320 | Port-A read data, lane i for bank i+1 |
| rd_b_o | output | 320 | Port-B read data, lane i for bank i+1 |
| wb_valid | input | 1 | Instruction writeback valid |
| wb_group | input | 4 | Writeback bank-group code |
| wb_splat | input | 2 | Writeback splat code |
| wb_rd | input | 5 | Writeback destination register |
| wb_res | input | 320 | Per-bank results, lane i from bank i+1 |
| ld_valid | input | 1 | Load-splat write valid |
| ld_all | input | 1 | Load splat to all banks (1) or banks 1 and 2 (0) |
| ld_rd | input | 5 | Load-splat destination register |
| ld_data | input | 64 | Load-splat data |
| wr_en_o | output | 5 | Per-bank write port enables this cycle |
| illegal_o | output | 1 | Reserved code on a valid issue or writeback |
| conflict_o | output | 1 | Load splat and instruction writeback share a bank |

## Verification
Two functions can fall in the same cycle and compete for a bank's single write port: an instruction writeback (lockstep or splat) and a load-splat write. The bench provokes this by driving both in one cycle. It pairs narrow and wide load splats with groups that overlap them, groups that do not, and illegal codes. It checks `conflict_o` and `wr_en_o` before the edge. After the edge it reads every bank back and compares each lane with a bench model in which the load data wins in the shared banks. The same sweep also crosses the read path with a write to the same register, to confirm that the old value is seen until the edge.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
   localparam int NBANK = 5;

   typedef enum logic [3:0] {
      GRP_B1     = 4'd0,
      GRP_B2     = 4'd1,
      GRP_B12    = 4'd2,
      GRP_NOT_B1 = 4'd3,
      GRP_EVERY  = 4'd4,
      GRP_B345   = 4'd5
   } grp_code_e;

   typedef enum logic [1:0] {
      SPL_OFF    = 2'd0,
      SPL_TO_B2  = 2'd1,
      SPL_TO_ALL = 2'd2,
      SPL_RSVD   = 2'd3
   } spl_code_e;

   localparam logic [NBANK-1:0] MASK_B1    = 5'b00001;
   localparam logic [NBANK-1:0] MASK_B2    = 5'b00010;
   localparam logic [NBANK-1:0] MASK_PAIR  = 5'b00011;
   localparam logic [NBANK-1:0] MASK_UPPER = 5'b11110;
   localparam logic [NBANK-1:0] MASK_ALL   = 5'b11111;
   localparam logic [NBANK-1:0] MASK_HI3   = 5'b11100;
endpackage

// File: rtl/mbank_grp_dec.sv
module mbank_grp_dec
   import mbank_pkg::*;
(
   input  logic [3:0]       grp,
   input  logic [1:0]       spl,
   output logic [NBANK-1:0] act,
   output logic [NBANK-1:0] tgt,
   output logic             bad
);
   always_comb begin
      act = '0;
      tgt = '0;
      bad = 1'b0;
      unique case (spl_code_e'(spl))
         SPL_OFF: begin
            unique case (grp)
               GRP_B1:     act = MASK_B1;
               GRP_B2:     act = MASK_B2;
               GRP_B12:    act = MASK_PAIR;
               GRP_NOT_B1: act = MASK_UPPER;
               GRP_EVERY:  act = MASK_ALL;
               GRP_B345:   act = MASK_HI3;
               default:    bad = 1'b1;
            endcase
         end
         SPL_TO_B2: begin
            act = MASK_B1;
            tgt = MASK_B2;
         end
         SPL_TO_ALL: begin
            act = MASK_B1;
            tgt = MASK_UPPER;
         end
         default: bad = 1'b1;
      endcase
   end

   always_comb begin
      if (bad) assert (act == '0 && tgt == '0) else $error("AST_DEC_BAD_EMPTY"); // R2
      if (spl != 2'd0 && !bad) assert (act == MASK_B1) else $error("AST_DEC_SPLAT_B1"); // R4
   end
endmodule

// File: rtl/mbank_bank.sv
module mbank_bank #(
   parameter int XLEN    = 64,
   parameter int NREG    = 32,
   parameter bit R0_ZERO = 1'b1,
   localparam int AW     = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   ra,
   input  logic [AW-1:0]   rb,
   output logic [XLEN-1:0] rda,
   output logic [XLEN-1:0] rdb,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd
);
   logic [XLEN-1:0] mem [NREG];
   logic            wr_ok;

   generate
      if (R0_ZERO) begin : g_zero
         assign wr_ok = we && (wa != '0);
         assign rda   = (ra == '0) ? '0 : mem[ra];
         assign rdb   = (rb == '0) ? '0 : mem[rb];
      end else begin : g_plain
         assign wr_ok = we;
         assign rda   = mem[ra];
         assign rdb   = mem[rb];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (wr_ok) begin
         mem[wa] <= wd;
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> mem[$past(wa)] == $past(wd)); // R10
   AST_R0_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (R0_ZERO && we && wa == '0) |=> $stable(mem[0])); // R7
endmodule

// File: rtl/mbank_wr_route.sv
module mbank_wr_route
   import mbank_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int AW   = 5,
   localparam int NB  = NBANK
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inst_go,
   input  logic [NB-1:0]      inst_act,
   input  logic [NB-1:0]      inst_tgt,
   input  logic [AW-1:0]      inst_rd,
   input  logic [NB*XLEN-1:0] inst_res,
   input  logic               ld_go,
   input  logic               ld_wide,
   input  logic [AW-1:0]      ld_rd,
   input  logic [XLEN-1:0]    ld_data,
   output logic [NB-1:0]      bank_we,
   output logic [NB*AW-1:0]   bank_wa,
   output logic [NB*XLEN-1:0] bank_wd,
   output logic               clash
);
   logic [NB-1:0] ld_mask;
   logic [NB-1:0] inst_hit;
   logic [NB-1:0] ld_hit;

   assign ld_mask  = ld_wide ? MASK_ALL : MASK_PAIR;
   assign ld_hit   = ld_go ? ld_mask : '0;
   assign inst_hit = inst_go ? (inst_act | inst_tgt) : '0;
   assign clash    = |(ld_hit & inst_hit);

   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [XLEN-1:0] own_res;
      assign own_res = inst_tgt[b] ? inst_res[0 +: XLEN] : inst_res[b*XLEN +: XLEN];

      always_comb begin
         bank_we[b]                = ld_hit[b] | inst_hit[b];
         bank_wa[b*AW +: AW]       = inst_rd;
         bank_wd[b*XLEN +: XLEN]   = own_res;
         if (ld_hit[b]) begin
            bank_wa[b*AW +: AW]     = ld_rd;
            bank_wd[b*XLEN +: XLEN] = ld_data;
         end
      end

      AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         ld_hit[b] |-> (bank_wd[b*XLEN +: XLEN] == ld_data && bank_wa[b*AW +: AW] == ld_rd)); // R9
   end

   AST_CLASH_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> (ld_go && inst_go)); // R9
endmodule

// File: rtl/mbank_rf.sv
module mbank_rf
   import mbank_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int NREG    = 32,
   parameter bit R0_ZERO = 1'b1,
   localparam int AW     = $clog2(NREG),
   localparam int NB     = NBANK
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iss_valid,
   input  logic [3:0]         iss_group,
   input  logic [1:0]         iss_splat,
   input  logic [AW-1:0]      iss_rs_a,
   input  logic [AW-1:0]      iss_rs_b,
   output logic [NB-1:0]      rd_en_o,
   output logic [NB*XLEN-1:0] rd_a_o,
   output logic [NB*XLEN-1:0] rd_b_o,
   input  logic               wb_valid,
   input  logic [3:0]         wb_group,
   input  logic [1:0]         wb_splat,
   input  logic [AW-1:0]      wb_rd,
   input  logic [NB*XLEN-1:0] wb_res,
   input  logic               ld_valid,
   input  logic               ld_all,
   input  logic [AW-1:0]      ld_rd,
   input  logic [XLEN-1:0]    ld_data,
   output logic [NB-1:0]      wr_en_o,
   output logic               illegal_o,
   output logic               conflict_o
);
   generate
      if (XLEN < 1) begin : g_bad_xlen
         $error("XLEN must be positive");
      end
      if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
         $error("NREG must be a power of two, at least 2");
      end
      if (NB != 5) begin : g_bad_nb
         $error("group table is defined for five banks");
      end
   endgenerate

   logic [NB-1:0] iss_act, iss_tgt_unused, wb_act, wb_tgt;
   logic          iss_bad, wb_bad;
   logic [NB-1:0]      bank_we;
   logic [NB*AW-1:0]   bank_wa;
   logic [NB*XLEN-1:0] bank_wd;

   mbank_grp_dec u_iss_dec (
      .grp (iss_group),
      .spl (iss_splat),
      .act (iss_act),
      .tgt (iss_tgt_unused),
      .bad (iss_bad)
   );

   mbank_grp_dec u_wb_dec (
      .grp (wb_group),
      .spl (wb_splat),
      .act (wb_act),
      .tgt (wb_tgt),
      .bad (wb_bad)
   );

   mbank_wr_route #(.XLEN(XLEN), .AW(AW)) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .inst_go  (wb_valid && !wb_bad),
      .inst_act (wb_act),
      .inst_tgt (wb_tgt),
      .inst_rd  (wb_rd),
      .inst_res (wb_res),
      .ld_go    (ld_valid),
      .ld_wide  (ld_all),
      .ld_rd    (ld_rd),
      .ld_data  (ld_data),
      .bank_we  (bank_we),
      .bank_wa  (bank_wa),
      .bank_wd  (bank_wd),
      .clash    (conflict_o)
   );

   assign rd_en_o   = iss_valid ? iss_act : '0;
   assign illegal_o = (iss_valid && iss_bad) || (wb_valid && wb_bad);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [XLEN-1:0] qa, qb;

      mbank_bank #(.XLEN(XLEN), .NREG(NREG), .R0_ZERO(R0_ZERO)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .ra    (iss_rs_a),
         .rb    (iss_rs_b),
         .rda   (qa),
         .rdb   (qb),
         .we    (bank_we[b]),
         .wa    (bank_wa[b*AW +: AW]),
         .wd    (bank_wd[b*XLEN +: XLEN])
      );

      assign rd_a_o[b*XLEN +: XLEN] = rd_en_o[b] ? qa : '0;
      assign rd_b_o[b*XLEN +: XLEN] = rd_en_o[b] ? qb : '0;

      if (R0_ZERO) begin : g_wen_r0
         assign wr_en_o[b] = bank_we[b] && (bank_wa[b*AW +: AW] != '0);
      end else begin : g_wen_plain
         assign wr_en_o[b] = bank_we[b];
      end
   end

   AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_bad && !ld_valid) |-> wr_en_o == '0); // R2
   AST_SPLAT_ONLY_B1: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && (iss_splat == 2'd1 || iss_splat == 2'd2)) |-> rd_en_o == MASK_B1); // R4
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wb_valid && !ld_valid) |-> wr_en_o == '0); // R3
endmodule

// File: tb/mbank_rf_test.sv
module mbank_rf_test;
   localparam int W  = 64;
   localparam int NB = 5;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_valid = 0; logic [3:0] iss_group = 0; logic [1:0] iss_splat = 0;
   logic [AW-1:0] iss_rs_a = 0, iss_rs_b = 0;
   logic [NB-1:0] rd_en_o;
   logic [NB*W-1:0] rd_a_o, rd_b_o;
   logic wb_valid = 0; logic [3:0] wb_group = 0; logic [1:0] wb_splat = 0;
   logic [AW-1:0] wb_rd = 0; logic [NB*W-1:0] wb_res = '0;
   logic ld_valid = 0, ld_all = 0; logic [AW-1:0] ld_rd = 0; logic [W-1:0] ld_data = '0;
   logic [NB-1:0] wr_en_o;
   logic illegal_o, conflict_o;

   int vectors = 0, errs = 0;
   bit done = 0;
   logic [W-1:0] model [NB][32];

   always #2 clk = ~clk;

   mbank_rf uut (.*);

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Bench copy of the group table (R1, R2, R4, R5)
   function automatic void exp_dec(input logic [3:0] g, input logic [1:0] s,
                                   output logic [4:0] act, output logic [4:0] tgt, output logic bad);
      act = 0; tgt = 0; bad = 0;
      if (s == 1) begin act = 5'b00001; tgt = 5'b00010; end
      else if (s == 2) begin act = 5'b00001; tgt = 5'b11110; end
      else if (s == 3) bad = 1;
      else begin
         case (g)
            0: act = 5'b00001; 1: act = 5'b00010; 2: act = 5'b00011;
            3: act = 5'b11110; 4: act = 5'b11111; 5: act = 5'b11100;
            default: bad = 1;
         endcase
      end
   endfunction

   task automatic idle();
      iss_valid = 0; wb_valid = 0; ld_valid = 0;
   endtask

   task automatic readback(string req, logic [AW-1:0] ra, logic [AW-1:0] rb);
      @(negedge clk);
      idle();
      iss_valid = 1; iss_group = 4; iss_splat = 0; iss_rs_a = ra; iss_rs_b = rb;
      #1;
      for (int b = 0; b < NB; b++) begin
         chk(req, rd_a_o[b*W +: W], model[b][ra]);
         chk(req, rd_b_o[b*W +: W], model[b][rb]);
      end
      iss_valid = 0;
   endtask

   // Drive one cycle of writes, check strobes, commit, update model
   task automatic do_write(string req, bit wv, logic [3:0] g, logic [1:0] s, logic [AW-1:0] rd,
                           bit lv, bit la, logic [AW-1:0] lrd, logic [W-1:0] ld, int tag);
      logic [4:0] act, tgt, ewr, lm, ihit; logic bad; logic [W-1:0] lane [NB];
      @(negedge clk);
      idle();
      exp_dec(g, s, act, tgt, bad);
      for (int b = 0; b < NB; b++) lane[b] = {16'hB0A0, 8'(g), 8'(s), 8'(b), 24'(tag)};
      wb_valid = wv; wb_group = g; wb_splat = s; wb_rd = rd;
      for (int b = 0; b < NB; b++) wb_res[b*W +: W] = lane[b];
      ld_valid = lv; ld_all = la; ld_rd = lrd; ld_data = ld;
      lm   = lv ? (la ? 5'b11111 : 5'b00011) : 5'b0;
      ihit = (wv && !bad) ? (act | tgt) : 5'b0;
      ewr = 0;
      for (int b = 0; b < NB; b++) begin
         if (lm[b]) ewr[b] = (lrd != 0);
         else if (ihit[b]) ewr[b] = (rd != 0);
      end
      #1;
      chk({req, " wr_en"}, W'(wr_en_o), W'(ewr));
      chk({req, " illegal"}, W'(illegal_o), W'(wv && bad));
      chk({req, " conflict"}, W'(conflict_o), W'(|(lm & ihit)));
      @(posedge clk);
      for (int b = 0; b < NB; b++) begin
         if (lm[b]) begin if (lrd != 0) model[b][lrd] = ld; end
         else if (ihit[b] && rd != 0) model[b][rd] = tgt[b] ? lane[0] : lane[b];
      end
      @(negedge clk);
      idle();
   endtask

   initial begin
      for (int b = 0; b < NB; b++) for (int r = 0; r < 32; r++) model[b][r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11: reset state
      for (int r = 0; r < 32; r += 5) readback("R11 reset clears", AW'(r), AW'(31 - r));
      #1;
      chk("R11 flags idle", W'({illegal_o, conflict_o, wr_en_o}), '0);

      // R1/R2/R4/R6: read-enable sweep over all codes
      for (int g = 0; g < 16; g++) begin
         for (int s = 0; s < 4; s++) begin
            logic [4:0] act, tgt; logic bad;
            @(negedge clk);
            exp_dec(4'(g), 2'(s), act, tgt, bad);
            iss_valid = 1; iss_group = 4'(g); iss_splat = 2'(s); iss_rs_a = 5'd3; iss_rs_b = 5'd4;
            #1;
            chk("R1 read enables", W'(rd_en_o), W'(act));
            chk("R2 illegal read", W'(illegal_o), W'(bad));
         end
      end
      iss_valid = 0;

      // R3/R4/R5/R2: writeback sweep over all codes with full readback
      for (int g = 0; g < 16; g++) begin
         for (int s = 0; s < 4; s++) begin
            int rd = ((g * 4 + s) % 31) + 1;
            do_write("R3 R4 R5 writeback", 1, 4'(g), 2'(s), AW'(rd), 0, 0, 0, '0, g * 4 + s);
            readback("R3 R4 R5 banks after write", AW'(rd), AW'((rd * 7) % 32));
         end
      end

      // R6: inactive lanes zero while data is nonzero
      @(negedge clk);
      iss_valid = 1; iss_group = 5; iss_splat = 0; iss_rs_a = 5'd1; iss_rs_b = 5'd2;
      #1;
      chk("R6 bank1 lane zero", rd_a_o[0 +: W], '0);
      chk("R6 bank2 lane zero", rd_b_o[W +: W], '0);
      chk("R6 bank3 own reg", rd_a_o[2*W +: W], model[2][1]);
      iss_valid = 0;

      // R7: write to register 0
      do_write("R7 r0 write", 1, 4, 0, 0, 0, 0, 0, '0, 900);
      readback("R7 r0 reads zero", 0, 0);
      do_write("R7 r0 load", 0, 0, 0, 0, 1, 1, 0, 64'hDEAD_0000_0000_BEEF, 901);
      readback("R7 r0 after load", 0, 0);

      // R8: load splats
      do_write("R8 load pair", 0, 0, 0, 0, 1, 0, 7, 64'h1111_2222_3333_4444, 910);
      readback("R8 pair banks", 7, 0);
      do_write("R8 load all", 0, 0, 0, 0, 1, 1, 8, 64'h5555_6666_7777_8888, 911);
      readback("R8 all banks", 8, 7);

      // R9: concurrent load splat and instruction writeback
      do_write("R9 overlap all", 1, 4, 0, 9, 1, 0, 9, 64'hAAAA_0000_0000_0001, 920);
      readback("R9 load wins", 9, 0);
      do_write("R9 no overlap", 1, 5, 0, 10, 1, 0, 11, 64'hAAAA_0000_0000_0002, 921);
      readback("R9 disjoint a", 10, 11);
      do_write("R9 splat vs wide load", 1, 0, 2, 12, 1, 1, 13, 64'hAAAA_0000_0000_0003, 922);
      readback("R9 wide load", 12, 13);
      do_write("R9 illegal with load", 1, 9, 0, 14, 1, 1, 14, 64'hAAAA_0000_0000_0004, 923);
      readback("R9 R2 illegal plus load", 14, 0);
      do_write("R9 splat b2 vs pair", 1, 3, 1, 15, 1, 0, 16, 64'hAAAA_0000_0000_0005, 924);
      readback("R9 splat b2 vs pair", 15, 16);

      // R10: same-cycle read sees old value
      @(negedge clk);
      iss_valid = 1; iss_group = 4; iss_splat = 0; iss_rs_a = 12; iss_rs_b = 12;
      wb_valid = 1; wb_group = 4; wb_splat = 0; wb_rd = 12;
      for (int b = 0; b < NB; b++) wb_res[b*W +: W] = 64'hC0FF_EE00_0000_0000 | 64'(b);
      #1;
      for (int b = 0; b < NB; b++) chk("R10 old value before edge", rd_a_o[b*W +: W], model[b][12]);
      @(posedge clk);
      for (int b = 0; b < NB; b++) model[b][12] = 64'hC0FF_EE00_0000_0000 | 64'(b);
      @(negedge clk);
      idle();
      readback("R10 new value after edge", 12, 12);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      done = 1;
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end
endmodule